// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that behaves like a small serial EEPROM holding 512 bytes. The system clock samples SCL and SDA through a two-flop synchronizer, and the block detects edges and bus conditions from the synchronized values. The block drives SDA only through a drive-low enable, so the pad stays open-drain. A control byte selects the device and carries the ninth address bit and the transfer direction. An internal address pointer then serves byte and page writes, current-address reads, random reads and sequential reads.

Written bytes go first into an 8-byte page buffer and reach the array only when STOP arrives. An internal write time follows, set by a parameter in system clock cycles. During that time the block ignores its own control byte. A write-protect input turns away data bytes. Reads run until the master answers a byte with NACK.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and it restarts control-byte reception from any state, including the middle of a byte. A STOP is SDA rising while SCL is high, and it returns the block to idle with SDA released.
- R2: A control byte is acknowledged only if bits 7..4 are 1010 and bits 3..2 are 00. Bit 1 is the block bit (address bit 8) and bit 0 is R/W, where 1 means read. If the byte does not match, SDA stays released until the next START.
- R3: In a write, the byte after the control byte sets the pointer to {block bit, byte}. Each data byte is acknowledged and lands at pointer bits 2..0 of the current 8-byte page. The pointer's low three bits then wrap within that page, so later bytes overwrite earlier ones.
- R4: Buffered bytes are copied into the array on STOP. For BUSY_CYCLES clock cycles after that, no control byte is acknowledged and SDA is never driven.
- R5: While wp_i is high, data bytes are not acknowledged and nothing is stored. No busy period follows, and the array keeps its contents.
- R6: The block changes read data only after an SCL falling edge and sends it MSB first. The pointer advances by one after each byte and wraps from 0x1FF to 0x000.
- R7: A random read is a dummy write of the address, then a repeated START and a read control byte. The master's ACK continues the read. A NACK ends it and leaves SDA released.
- R8: A current-address read starts at the pointer left by the last access.
- R9: After reset, SDA is released, the pointer is 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| wp_i | input | 1 | Write protect, high inhibits writes |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
The bench writes pages at several offsets with more than eight bytes, so the last bytes wrap onto the first ones. A design that carried the pointer into the next page would put data in the wrong page, and the read-back would not match. A sequential read across 0x1FF catches a pointer that saturates or jumps. A START issued after four bits must still yield a clean transaction, which exposes a bit counter that is not cleared. Control bytes sent during the write time, or with a wrong device code, must be refused. Data sent under write protect must be refused and leave no busy period behind; a design that stored it or started the write timer would show up in the later ACK and the later read.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_CTRL_ACK, S_WADDR, S_WADDR_ACK,
    S_WDATA, S_WDATA_ACK, S_TX, S_TX_ACK
  } st_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_d_q, sda_d_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_d_q    <= scl_s;
      sda_d_q    <= sda_s;
    end
  end

  assign scl_s      = scl_sync_q[SYNC_STAGES-1];
  assign sda_s      = sda_sync_q[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d_q;
  assign scl_fall_o = ~scl_s & scl_d_q;
  // bus conditions need SCL high on both samples
  assign start_o    = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_o     = scl_s & scl_d_q & ~sda_d_q & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_BYTES = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] idx_i,
  input  logic [7:0]                    data_i,
  output logic [PAGE_BYTES*8-1:0]       data_o,
  output logic [PAGE_BYTES-1:0]         valid_o
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] byte_q;
    logic       vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end else if (wr_i && idx_i == IDX_W'(g)) begin
        byte_q <= data_i;
        vld_q  <= 1'b1;
      end
    end
    assign data_o[g*8 +: 8] = byte_q;
    assign valid_o[g]       = vld_q;
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 8
) (
  input  logic                                             clk_i,
  input  logic                                             rst_ni,
  input  logic                                             commit_i,
  input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0]  page_i,
  input  logic [PAGE_BYTES*8-1:0]                          buf_data_i,
  input  logic [PAGE_BYTES-1:0]                            buf_valid_i,
  input  logic [$clog2(MEM_BYTES)-1:0]                     raddr_i,
  output logic [7:0]                                       rdata_o
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  logic [7:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (buf_valid_i[j]) mem_q[{page_i, IDX_W'(j)}] <= buf_data_i[j*8 +: 8];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int         MEM_BYTES   = 512,   // 512, 1024 or 2048
  parameter int         PAGE_BYTES  = 8,
  parameter int         BUSY_CYCLES = 500000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter logic [2:0] DEV_SEL     = 3'b000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  localparam int         ADDR_W   = $clog2(MEM_BYTES);
  localparam int         IDX_W    = $clog2(PAGE_BYTES);
  localparam int         BLK_W    = ADDR_W - 8;
  localparam int         BUSY_W   = $clog2(BUSY_CYCLES + 1);
  localparam logic [2:0] SEL_MASK = 3'b111 << BLK_W;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  st_e                   st_q;
  logic [3:0]            cnt_q;
  logic [7:0]            sr_q, rdata;
  logic [ADDR_W-1:0]     ptr_q;
  logic [BLK_W-1:0]      blk_q;
  logic                  rw_q, oe_q, mack_q;
  logic [BUSY_W-1:0]     busy_q;
  logic                  busy, byte_end, ctrl_ok, pb_wr, commit;
  logic [PAGE_BYTES*8-1:0] pb_data;
  logic [PAGE_BYTES-1:0] pb_valid;

  assign busy     = (busy_q != '0);
  assign byte_end = scl_fall && (cnt_q == 4'd8);
  assign ctrl_ok  = (sr_q[7:4] == DEV_CODE) && (((sr_q[3:1] ^ DEV_SEL) & SEL_MASK) == 3'b000) && !busy;
  assign pb_wr    = !start_ev && !stop_ev && (st_q == S_WDATA) && byte_end && !wp_i;
  assign commit   = stop_ev && (|pb_valid);

  eeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(start_ev | stop_ev), .wr_i(pb_wr), .idx_i(ptr_q[IDX_W-1:0]),
    .data_i(sr_q), .data_o(pb_data), .valid_o(pb_valid)
  );

  eeprom_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk_i, .rst_ni,
    .commit_i(commit), .page_i(ptr_q[ADDR_W-1:IDX_W]),
    .buf_data_i(pb_data), .buf_valid_i(pb_valid),
    .raddr_i(ptr_q), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else if (commit) busy_q <= BUSY_W'(BUSY_CYCLES);
    else if (busy) busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sr_q   <= '0;
      ptr_q  <= '0;
      blk_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_ev) begin
      st_q  <= S_CTRL;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_ev) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_CTRL, S_WADDR, S_WDATA: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sr_q  <= {sr_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_end) begin
            cnt_q <= '0;
            if (st_q == S_CTRL) begin
              if (ctrl_ok) begin
                oe_q  <= 1'b1;
                blk_q <= sr_q[BLK_W:1];
                rw_q  <= sr_q[0];
                st_q  <= S_CTRL_ACK;
              end else st_q <= S_IDLE;
            end else if (st_q == S_WADDR) begin
              oe_q  <= 1'b1;
              ptr_q <= {blk_q, sr_q};
              st_q  <= S_WADDR_ACK;
            end else if (!wp_i) begin
              oe_q <= 1'b1;
              ptr_q[IDX_W-1:0] <= ptr_q[IDX_W-1:0] + IDX_W'(1);
              st_q <= S_WDATA_ACK;
            end else st_q <= S_IDLE;
          end
        end
        S_CTRL_ACK: if (scl_fall) begin
          if (rw_q) begin
            sr_q  <= rdata;
            oe_q  <= ~rdata[7];
            ptr_q <= ptr_q + 1'b1;
            st_q  <= S_TX;
          end else begin
            oe_q <= 1'b0;
            st_q <= S_WADDR;
          end
        end
        S_WADDR_ACK, S_WDATA_ACK: if (scl_fall) begin
          oe_q <= 1'b0;
          st_q <= S_WDATA;
        end
        S_TX: begin
          if (scl_rise) cnt_q <= cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= S_TX_ACK;
            end else begin
              sr_q <= {sr_q[6:0], 1'b1};
              oe_q <= ~sr_q[6];
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              sr_q  <= rdata;
              oe_q  <= ~rdata[7];
              ptr_q <= ptr_q + 1'b1;
              st_q  <= S_TX;
            end else st_q <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic start_i,
  input logic stop_i,
  input logic scl_fall_i,
  input logic busy_i,
  input logic commit_i
);
  AST_RESET_RELEASED: assert property (@(posedge clk_i)
    !rst_ni |-> !sda_oe_o); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R1

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> $past(scl_fall_i)); // R6

  AST_BUSY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_o); // R4

  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> busy_i); // R4
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o),
  .start_i(start_ev), .stop_i(stop_ev), .scl_fall_i(scl_fall),
  .busy_i(busy), .commit_i(commit)
);

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;
  localparam int BUSY = 1500;
  localparam int Q    = 100;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_bus;
  int   n_chk = 0, n_bad = 0;
  logic [7:0] model [512];

  assign sda_bus = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  i2c_eeprom_slave #(.BUSY_CYCLES(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; #Q; scl = 1'b1; #Q; scl = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; #Q; scl = 1'b1; #(Q/2); ack = ~sda_bus; #(Q/2); scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic ack_m, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1'b1; #(Q/2); b[i] = sda_bus; #(Q/2); scl = 1'b0;
    end
    #Q; sda_m = ~ack_m; #Q; scl = 1'b1; #Q; scl = 1'b0; #Q; sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctrl(input logic [8:0] a, input logic rd);
    return {4'b1010, 2'b00, a[8], rd};
  endfunction

  task automatic write_seq(input logic [8:0] a, input int n, input logic [7:0] base, input bit wait_done);
    logic ack;
    i2c_start();
    send_byte(ctrl(a, 1'b0), ack); chk("R3 ctrl ack", ack, 1);
    send_byte(a[7:0], ack);        chk("R3 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = base + 8'(i * 13);
      send_byte(d, ack); chk("R3 data ack", ack, 1);
      model[{a[8:3], 3'(a[2:0] + 3'(i))}] = d;
    end
    i2c_stop();
    if (wait_done) #(BUSY * 10 + 200);
  endtask

  task automatic read_rand(input logic [8:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte(ctrl(a, 1'b0), ack); chk({req, " dummy ctrl ack"}, ack, 1);
    send_byte(a[7:0], ack);        chk({req, " addr ack"}, ack, 1);
    i2c_start();
    send_byte(ctrl(a, 1'b1), ack); chk({req, " read ctrl ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk({req, " data"}, d, model[9'(a + 9'(i))]);
    end
    chk({req, " R7 released after NACK"}, sda_oe, 0);
    i2c_stop();
  endtask

  task automatic read_cur(input logic [8:0] a, input int n);
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte(ctrl(9'h0, 1'b1), ack); chk("R8 ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk("R8 current read data", d, model[9'(a + 9'(i))]);
    end
    i2c_stop();
  endtask

  initial begin
    #(190000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    #100; rst_n = 1'b1; #100;
    chk("R9 sda released after reset", sda_oe, 0);
    // R9: erased array and pointer at 0
    read_cur(9'h000, 2);
    read_rand(9'h0A3, 2, "R9 erased");

    // R3: page sweep with offsets and wrap beyond 8 bytes
    for (int p = 0; p < 6; p++) begin
      logic [8:0] a;
      a = 9'((p * 72) + p);
      write_seq(a, (p % 2 == 0) ? 8 : 11, 8'(p * 31 + 5), 1'b1);
      read_rand({a[8:3], 3'b000}, 8, "R3 page readback");
    end

    // R2 block bit selects upper half
    write_seq(9'h105, 3, 8'h40, 1'b1);
    read_rand(9'h105, 3, "R2 block bit");

    // R6 sequential read wraps 0x1FF to 0x000
    write_seq(9'h1FE, 2, 8'hC3, 1'b1);
    read_rand(9'h1FD, 5, "R6 wrap");
    read_cur(9'h002, 2);

    // R4 busy window refuses control byte
    write_seq(9'h020, 1, 8'h77, 1'b0);
    i2c_start(); send_byte(ctrl(9'h0, 1'b0), ack); chk("R4 nack while busy", ack, 0);
    i2c_stop();
    #(BUSY * 10 + 200);
    read_rand(9'h020, 1, "R4 committed after busy");

    // R5 write protect
    wp = 1'b1;
    i2c_start();
    send_byte(ctrl(9'h030, 1'b0), ack); chk("R5 ctrl ack", ack, 1);
    send_byte(8'h30, ack);              chk("R5 addr ack", ack, 1);
    send_byte(8'h5A, ack);              chk("R5 data nack", ack, 0);
    i2c_stop();
    wp = 1'b0;
    i2c_start(); send_byte(ctrl(9'h0, 1'b0), ack); chk("R5 no busy after protected write", ack, 1);
    i2c_stop();
    read_rand(9'h030, 1, "R5 unchanged");

    // R2 wrong device code and wrong select bits
    i2c_start(); send_byte(8'hB0, ack); chk("R2 wrong code nack", ack, 0);
    chk("R2 sda released", sda_oe, 0);
    send_byte(8'hFF, ack); chk("R2 ignored until start", ack, 0);
    i2c_stop();
    i2c_start(); send_byte(8'hA8, ack); chk("R2 wrong select nack", ack, 0);
    i2c_stop();

    // R1 START in the middle of a byte
    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_start();
    send_byte(ctrl(9'h105, 1'b0), ack); chk("R1 ctrl after mid-byte start", ack, 1);
    send_byte(8'h05, ack);              chk("R1 addr ack", ack, 1);
    i2c_start();
    send_byte(ctrl(9'h105, 1'b1), ack); chk("R1 read ctrl ack", ack, 1);
    recv_byte(1'b0, d); chk("R1 data", d, model[9'h105]);
    i2c_stop();
    chk("R1 released after stop", sda_oe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule